// File: doc/BRIEF.md
# Prioritized Memory Bank Address Decoder

This block decides which external memory bank serves each bus access. It holds eight programmable banks. Every bank has a base register that carries a 17-bit base tag, a valid bit, a read-only flag, a two-bit controller-machine field and a flag that assigns the bank to the local bus. Every bank also has a mask register that carries a 17-bit mask. Only the 17 most significant bits of a 32-bit address take part in the compare, so a bank covers anything from 32 KB up to the whole 4 GB space.

Requests arrive from one of two masters, the system bus or the local bus, with an address and a write flag. One cycle after the request strobe, the block reports one of three results. On a grant it shows the winning bank index, a one-hot chip select, the controller machine and a hand-over flag, and it keeps all of these until the end-of-cycle input. On a refused write it gives a one-cycle protection error. When no bank claims the access it gives a one-cycle miss pulse, so that an external bus slave can take the access. The banks are programmed through a plain write port.

Top module: `memsel_decoder`

## Requirements
- R1: After reset no bank is valid, `own_busy`, `miss`, `prot_err` and `reroute` are 0, and `bank_cs` is all zeros.
- R2: A base write (`cfg_is_mask`=0) stores bits 31:15 as the base tag, bit 0 as valid, bit 1 as read-only, bits 3:2 as machine and bit 4 as local-bus assignment. A mask write (`cfg_is_mask`=1) stores bits 31:15 as the mask. A bank hits when (`req_addr[31:15]` AND mask) equals the base tag.
- R3: A bank whose valid bit is 0 never hits.
- R4: When several eligible banks hit, the lowest-numbered one wins.
- R5: The registered results appear on the first clock edge after the cycle in which `req_valid` is high. On a grant, `bank_cs` is one-hot at the winner's index, `bank_idx` equals that index and `mach_sel` equals the winner's machine field.
- R6: A system-bus request (`req_local`=0) whose winning bank is assigned to the local bus is granted with `reroute`=1. The result is `reroute`=0 when the winning bank belongs to the system bus.
- R7: A local-bus request (`req_local`=1) ignores every bank assigned to the system bus. A higher-numbered local bank can then win, or the request misses.
- R8: A write whose winning bank is read-only raises `prot_err` for one cycle, asserts no chip select and takes no ownership. A read of the same bank is granted.
- R9: A request that no eligible bank hits raises `miss` for one cycle and asserts no chip select.
- R10: While `own_busy` is 1, new requests are ignored, and `bank_cs`, `bank_idx`, `mach_sel` and `reroute` hold their values.
- R11: `end_cycle` during ownership clears `own_busy`, `bank_cs`, `bank_idx`, `mach_sel` and `reroute` on the next edge. `end_cycle` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_is_mask | input | 1 | 1 selects the mask register, 0 selects the base register |
| cfg_bank | input | 3 | Bank index being written |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Access request strobe |
| req_local | input | 1 | 1 for a local-bus request, 0 for a system-bus request |
| req_write | input | 1 | 1 for a write access |
| req_addr | input | 32 | Access address |
| end_cycle | input | 1 | Ends the owned cycle |
| own_busy | output | 1 | A controller owns the external signals |
| bank_cs | output | 8 | One-hot chip select |
| bank_idx | output | 3 | Winning bank index |
| mach_sel | output | 2 | Controller machine of the winning bank |
| reroute | output | 1 | Granted system access is handed to the local bus |
| miss | output | 1 | One-cycle no-match pulse |
| prot_err | output | 1 | One-cycle write-to-read-only pulse |

## Verification
Every result is one register deep. A request strobe driven at a falling edge is read at the following falling edge, after exactly one rising edge. A configuration write takes effect at that same rising edge, so it is in use for the next request. The `miss` and `prot_err` pulses are sampled in the result cycle and again one cycle later, which shows that each lasts exactly one cycle. A release by `end_cycle` is checked one edge after the strobe, and a request sent during ownership is checked one edge after it was sent.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

    localparam int ADDR_W = 32;
    localparam int CMP_W  = 17;
    localparam int MACH_W = 2;
    localparam int TAG_LO = ADDR_W - CMP_W;

    // base register field positions (decoded by software and the regfile)
    localparam int BF_VALID = 0;
    localparam int BF_RO    = 1;
    localparam int BF_MACH  = 2;
    localparam int BF_LOCAL = BF_MACH + MACH_W;

    typedef struct packed {
        logic [CMP_W-1:0]  base;
        logic [CMP_W-1:0]  mask;
        logic              valid;
        logic              ro;
        logic [MACH_W-1:0] mach;
        logic              on_local;
    } bank_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OWN  = 1'b1
    } own_state_t;

endpackage

// File: rtl/memsel_regfile.sv
module memsel_regfile
    import memsel_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      cfg_is_mask,
    input  logic [BANK_W-1:0]         cfg_bank,
    input  logic [ADDR_W-1:0]         cfg_wdata,
    output bank_cfg_t [NUM_BANKS-1:0] cfg
);

    bank_cfg_t [NUM_BANKS-1:0] cfg_d, cfg_q;

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata[TAG_LO-1:BF_LOCAL+1];

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (cfg_is_mask) begin
                cfg_d[cfg_bank].mask = cfg_wdata[ADDR_W-1:TAG_LO];
            end else begin
                cfg_d[cfg_bank].base     = cfg_wdata[ADDR_W-1:TAG_LO];
                cfg_d[cfg_bank].valid    = cfg_wdata[BF_VALID];
                cfg_d[cfg_bank].ro       = cfg_wdata[BF_RO];
                cfg_d[cfg_bank].mach     = cfg_wdata[BF_MACH +: MACH_W];
                cfg_d[cfg_bank].on_local = cfg_wdata[BF_LOCAL];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/memsel_match.sv
module memsel_match
    import memsel_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  bank_cfg_t [NUM_BANKS-1:0] cfg,
    input  logic [CMP_W-1:0]          tag,
    input  logic                      from_local,
    output logic [NUM_BANKS-1:0]      eligible
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        logic bus_ok;
        assign hit    = cfg[b].valid && ((tag & cfg[b].mask) == cfg[b].base);
        // local masters see only local banks; system masters see all
        assign bus_ok = from_local ? cfg[b].on_local : 1'b1;
        assign eligible[b] = hit && bus_ok;
    end

endmodule

// File: rtl/memsel_prio.sv
module memsel_prio #(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS-1:0] req_vec,
    output logic                 found,
    output logic [BANK_W-1:0]    win_idx,
    output logic [NUM_BANKS-1:0] win_onehot
);

    always_comb begin
        win_idx = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (req_vec[i]) begin
                win_idx = BANK_W'(i);
            end
        end
        found      = |req_vec;
        win_onehot = found ? (NUM_BANKS'(1) << win_idx) : '0;
    end

endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
    import memsel_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_is_mask,
    input  logic [BANK_W-1:0]    cfg_bank,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    input  logic                 req_valid,
    input  logic                 req_local,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 end_cycle,
    output logic                 own_busy,
    output logic [NUM_BANKS-1:0] bank_cs,
    output logic [BANK_W-1:0]    bank_idx,
    output logic [MACH_W-1:0]    mach_sel,
    output logic                 reroute,
    output logic                 miss,
    output logic                 prot_err
);

    typedef struct packed {
        own_state_t           st;
        logic [NUM_BANKS-1:0] cs;
        logic [BANK_W-1:0]    idx;
        logic [MACH_W-1:0]    mach;
        logic                 reroute;
        logic                 miss;
        logic                 prot;
    } dec_state_t;

    bank_cfg_t [NUM_BANKS-1:0] cfg;
    logic [NUM_BANKS-1:0]      eligible;
    logic                      found;
    logic [BANK_W-1:0]         win_idx;
    logic [NUM_BANKS-1:0]      win_onehot;
    dec_state_t                s_d, s_q;

    logic unused_addr;
    assign unused_addr = ^req_addr[TAG_LO-1:0];

    memsel_regfile #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_is_mask (cfg_is_mask),
        .cfg_bank    (cfg_bank),
        .cfg_wdata   (cfg_wdata),
        .cfg         (cfg)
    );

    memsel_match #(.NUM_BANKS(NUM_BANKS)) u_match (
        .cfg        (cfg),
        .tag        (req_addr[ADDR_W-1:TAG_LO]),
        .from_local (req_local),
        .eligible   (eligible)
    );

    memsel_prio #(.NUM_BANKS(NUM_BANKS)) u_prio (
        .req_vec    (eligible),
        .found      (found),
        .win_idx    (win_idx),
        .win_onehot (win_onehot)
    );

    always_comb begin
        s_d      = s_q;
        s_d.miss = 1'b0;
        s_d.prot = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!found) begin
                        s_d.miss = 1'b1;
                    end else if (req_write && cfg[win_idx].ro) begin
                        s_d.prot = 1'b1;
                    end else begin
                        s_d.st      = ST_OWN;
                        s_d.cs      = win_onehot;
                        s_d.idx     = win_idx;
                        s_d.mach    = cfg[win_idx].mach;
                        s_d.reroute = !req_local && cfg[win_idx].on_local;
                    end
                end
            end
            ST_OWN: begin
                // owner is frozen; only end of cycle releases it
                if (end_cycle) begin
                    s_d.st      = ST_IDLE;
                    s_d.cs      = '0;
                    s_d.idx     = '0;
                    s_d.mach    = '0;
                    s_d.reroute = 1'b0;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign own_busy = (s_q.st == ST_OWN);
    assign bank_cs  = s_q.cs;
    assign bank_idx = s_q.idx;
    assign mach_sel = s_q.mach;
    assign reroute  = s_q.reroute;
    assign miss     = s_q.miss;
    assign prot_err = s_q.prot;

endmodule

// File: rtl/memsel_decoder_chk.sv
module memsel_decoder_chk #(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 end_cycle,
    input logic                 own_busy,
    input logic [NUM_BANKS-1:0] bank_cs,
    input logic [BANK_W-1:0]    bank_idx,
    input logic [1:0]           mach_sel,
    input logic                 reroute,
    input logic                 miss,
    input logic                 prot_err
);

    AST_CS_ONEHOT_WHEN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        own_busy |-> $onehot(bank_cs)); // R5
    AST_CS_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !own_busy |-> (bank_cs == '0)); // R1
    AST_GRANT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_busy) |-> $past(req_valid)); // R5
    AST_MISS_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (!own_busy && bank_cs == '0 && $past(req_valid))); // R9
    AST_PROT_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> (!own_busy && bank_cs == '0 && !miss)); // R8
    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (own_busy && !end_cycle) |=> (own_busy && $stable(bank_cs) && $stable(bank_idx)
                                      && $stable(mach_sel) && $stable(reroute))); // R10
    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (own_busy && end_cycle) |=> (!own_busy && bank_cs == '0 && !reroute)); // R11

endmodule

bind memsel_decoder memsel_decoder_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .end_cycle (end_cycle),
    .own_busy  (own_busy),
    .bank_cs   (bank_cs),
    .bank_idx  (bank_idx),
    .mach_sel  (mach_sel),
    .reroute   (reroute),
    .miss      (miss),
    .prot_err  (prot_err)
);

// File: tb/memsel_decoder_tb.sv
module memsel_decoder_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_is_mask = 1'b0;
    logic [2:0]  cfg_bank = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_local = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        end_cycle = 1'b0;
    logic        own_busy;
    logic [7:0]  bank_cs;
    logic [2:0]  bank_idx;
    logic [1:0]  mach_sel;
    logic        reroute;
    logic        miss;
    logic        prot_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    memsel_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_mask(cfg_is_mask),
        .cfg_bank(cfg_bank), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_local(req_local), .req_write(req_write), .req_addr(req_addr),
        .end_cycle(end_cycle), .own_busy(own_busy), .bank_cs(bank_cs),
        .bank_idx(bank_idx), .mach_sel(mach_sel), .reroute(reroute),
        .miss(miss), .prot_err(prot_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_base(input int b, input logic [16:0] base, input logic vld,
                           input logic ro, input logic [1:0] mach, input logic loc);
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_mask = 1'b0; cfg_bank = 3'(b);
        cfg_wdata = {base, 10'b0, loc, mach, ro, vld};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_mask(input int b, input logic [16:0] mask);
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_mask = 1'b1; cfg_bank = 3'(b);
        cfg_wdata = {mask, 15'b0};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // request strobe for one cycle; returns at the result cycle
    task automatic send(input logic loc, input logic wr, input logic [31:0] addr);
        @(negedge clk);
        req_valid = 1'b1; req_local = loc; req_write = wr; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic release_owner();
        @(negedge clk);
        end_cycle = 1'b1;
        @(negedge clk);
        end_cycle = 1'b0;
    endtask

    task automatic expect_grant(input string tag, input int b, input logic [1:0] m, input logic rr);
        chk({tag, " busy"}, 32'(own_busy), 1);
        chk({tag, " cs"}, 32'(bank_cs), 32'(8'(1) << b));
        chk({tag, " idx"}, 32'(bank_idx), 32'(b));
        chk({tag, " mach"}, 32'(mach_sel), 32'(m));
        chk({tag, " reroute"}, 32'(reroute), 32'(rr));
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(own_busy), 0);
        chk("R1 cs", 32'(bank_cs), 0);
        chk("R1 miss", 32'(miss), 0);
        chk("R1 prot", 32'(prot_err), 0);
        chk("R1 reroute", 32'(reroute), 0);
        send(1'b0, 1'b0, 32'h0000_0000);
        chk("R1 no valid bank -> miss", 32'(miss), 1);
    endtask

    task automatic t_program();
        wr_mask(0, 17'h1F000); wr_base(0, 17'h00000, 1, 1, 2'd0, 0);
        wr_mask(1, 17'h1FFFF); wr_base(1, 17'h00010, 1, 0, 2'd1, 0);
        wr_mask(2, 17'h1F000); wr_base(2, 17'h08000, 1, 0, 2'd2, 1);
        wr_mask(3, 17'h1F000); wr_base(3, 17'h08000, 1, 0, 2'd3, 0);
        wr_mask(4, 17'h1F000); wr_base(4, 17'h10000, 1, 0, 2'd3, 0);
        wr_mask(5, 17'h1F000); wr_base(5, 17'h10000, 1, 0, 2'd1, 1);
        wr_mask(6, 17'h1F000); wr_base(6, 17'h18000, 0, 0, 2'd2, 0);
    endtask

    task automatic t_match_and_priority();
        send(1'b0, 1'b0, 32'h0008_0000);   // banks 0 and 1 both hit
        expect_grant("R4 lowest bank wins", 0, 2'd0, 0);
        release_owner();
        send(1'b0, 1'b0, 32'h8123_4560);   // R2 masked compare, low bits ignored
        expect_grant("R2 masked match", 4, 2'd3, 0);
        release_owner();
    endtask

    task automatic t_reroute();
        send(1'b0, 1'b0, 32'h4000_0000);
        expect_grant("R6 sys to local bank", 2, 2'd2, 1);
        release_owner();
    endtask

    task automatic t_local_skip();
        send(1'b1, 1'b0, 32'h8000_0000);
        expect_grant("R7 local skips sys bank", 5, 2'd1, 0);
        release_owner();
        send(1'b1, 1'b0, 32'h0008_0000);
        chk("R7 local only sys banks -> miss", 32'(miss), 1);
        chk("R7 no cs", 32'(bank_cs), 0);
    endtask

    task automatic t_protect();
        send(1'b0, 1'b1, 32'h0000_1000);
        chk("R8 prot_err", 32'(prot_err), 1);
        chk("R8 no cs", 32'(bank_cs), 0);
        chk("R8 no ownership", 32'(own_busy), 0);
        @(negedge clk);
        chk("R8 prot pulse one cycle", 32'(prot_err), 0);
        send(1'b0, 1'b0, 32'h0000_1000);
        expect_grant("R8 read of ro bank", 0, 2'd0, 0);
        release_owner();
    endtask

    task automatic t_miss_and_valid();
        send(1'b0, 1'b0, 32'hF000_0000);
        chk("R9 miss", 32'(miss), 1);
        chk("R9 no cs", 32'(bank_cs), 0);
        @(negedge clk);
        chk("R9 miss pulse one cycle", 32'(miss), 0);
        send(1'b0, 1'b0, 32'hC000_0000);
        chk("R3 invalid bank misses", 32'(miss), 1);
        wr_base(6, 17'h18000, 1, 0, 2'd2, 0);
        send(1'b0, 1'b0, 32'hC000_0000);
        expect_grant("R3 after valid set", 6, 2'd2, 0);
        release_owner();
    endtask

    task automatic t_ownership();
        send(1'b0, 1'b0, 32'h8000_0000);
        expect_grant("R5 grant next cycle", 4, 2'd3, 0);
        send(1'b0, 1'b0, 32'h4000_0000);   // ignored while owned
        expect_grant("R10 held during busy", 4, 2'd3, 0);
        @(negedge clk);
        end_cycle = 1'b1;
        @(negedge clk);
        end_cycle = 1'b0;
        chk("R11 busy released", 32'(own_busy), 0);
        chk("R11 cs released", 32'(bank_cs), 0);
        chk("R11 idx cleared", 32'(bank_idx), 0);
        release_owner();                   // end_cycle while idle
        chk("R11 idle end no effect", 32'(own_busy), 0);
        send(1'b0, 1'b0, 32'h4000_0000);
        expect_grant("R11 decode after idle end", 2, 2'd2, 1);
        release_owner();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_match_and_priority();
        t_reroute();
        t_local_skip();
        t_protect();
        t_miss_and_valid();
        t_ownership();
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule